// File: doc/BRIEF.md
# Envelope-Indexed Lookup-Table Predistorter (Forward Path)

This block sits in the transmit chain ahead of a power amplifier. It accepts one baseband I/Q sample per clock and forms the sample's squared envelope. From that value it derives an address into a complex gain table. It multiplies the sample by the gain it reads and emits the corrected I/Q pair with a valid flag. The pipeline has a fixed latency, and a delay line carries each sample alongside its own table read. Every output is therefore corrected by the gain chosen for that sample.

A second table port takes coefficient writes from an adaptation processor while samples keep streaming. The datapath never stalls for a write. A write that lands in the same cycle as a read of the same entry is not yet seen by that read. After reset the table holds unity gain, so the block is transparent until it is trained.

Top module: `lut_predistorter`

## Requirements
- R1: Reset is synchronous and active low. While reset is low and on the first cycle after it, `out_valid`, `out_i` and `out_q` are 0. Reset returns every table entry to unity gain (gain I term 1024, gain Q term 0), so samples pass through unchanged.
- R2: `out_valid` equals the `in_valid` value sampled 5 rising edges earlier. A new sample is accepted on every cycle, including cycles in which a coefficient write occurs.
- R3: With m = I·I + Q·Q computed from the signed 16-bit inputs, the table address is 127 when m ≥ 2^30, and floor(m / 2^23) otherwise.
- R4: Each gain term is a 12-bit two's complement number with 10 fraction bits. With gain terms gi and gq, out_i = floor((I·gi − Q·gq + 512) / 1024) and out_q = floor((Q·gi + I·gq + 512) / 1024). This is a full complex product rounded half up.
- R5: Results outside the signed 16-bit range saturate to 32767 or −32768.
- R6: When `cw_en` is high at a rising edge, table entry `cw_addr` takes `cw_i` as its I term and `cw_q` as its Q term. A sample presented at edge k reads the table at edge k+2. A write at edge w is used by every sample whose read edge is later than w.
- R7: If a write and a sample's read hit the same entry at the same edge, that sample uses the value held before the write.
- R8: Back-to-back samples that select different entries are each corrected by their own entry, with no mixing across neighbouring samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 7 | Table entry to write |
| cw_i | input | 12 | Gain I term to write, signed, 10 fraction bits |
| cw_q | input | 12 | Gain Q term to write, signed, 10 fraction bits |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Predistorted in-phase sample, signed |
| out_q | output | 16 | Predistorted quadrature sample, signed |

## Verification
The embedded properties assume that `in_valid`, the sample and the write port carry known values once reset is released. The unity-gain passthrough property only applies when the gain read is exactly 1024 and 0. The write property assumes that at most one write is issued per edge.

The stimulus holds `in_valid` and `cw_en` low throughout reset and drives every input away from the clock edge. It keeps written gain terms inside the 12-bit signed range. It aims samples at exact address boundaries, at full-scale corners and at a write that collides with a read.

// File: rtl/lpd_pkg.sv
// Shared sizing for the lookup-table predistorter.
// Assumes: all modules of the block take their default widths from here.
package lpd_pkg;
    localparam int SAMPLE_W  = 16;  // signed I and Q sample width
    localparam int COEF_W    = 12;  // signed gain term width
    localparam int COEF_FRAC = 10;  // fraction bits of a gain term
    localparam int TBL_AW    = 7;   // table address width (128 entries)
endpackage

// File: rtl/lpd_addr_map.sv
// Squared-envelope address map.
// Forms I*I + Q*Q in one stage, then scales it to a table address in a
// second stage. Values at or beyond full scale clamp to the last entry.
// Assumes: signed SW-bit inputs, so each square is at most 2^(2*SW-2).
module lpd_addr_map #(
    parameter int SW = lpd_pkg::SAMPLE_W,
    parameter int AW = lpd_pkg::TBL_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    output logic                 addr_valid,
    output logic [AW-1:0]        addr
);
    localparam int MW   = 2 * SW;      // square width
    localparam int FULL = 2 * SW - 2;  // bit weight of full scale
    localparam int SH   = FULL - AW;   // shift from envelope to address

    logic signed [MW-1:0] prod_i, prod_q;
    logic [MW-1:0]        sq_i, sq_q, magsq;
    logic                 sq_valid;
    logic [AW-1:0]        addr_c;
    logic [SH-1:0]        unused_low;

    assign prod_i = MW'(in_i) * MW'(in_i);
    assign prod_q = MW'(in_q) * MW'(in_q);

    // Stage 1: register the two squares
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_i     <= '0;
            sq_q     <= '0;
            sq_valid <= 1'b0;
        end else begin
            sq_i     <= prod_i;
            sq_q     <= prod_q;
            sq_valid <= in_valid;
        end
    end

    assign magsq      = sq_i + sq_q;
    assign unused_low = magsq[SH-1:0];

    // Scale the envelope to an address, clamping at full scale
    always_comb begin
        if (|magsq[MW-1:FULL]) addr_c = '1;
        else                   addr_c = magsq[FULL-1:SH];
    end

    // Stage 2: register the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr       <= '0;
            addr_valid <= 1'b0;
        end else begin
            addr       <= addr_c;
            addr_valid <= sq_valid;
        end
    end

    // R3
    zero_env_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_i == '0 && in_q == '0) |-> ##2 (addr == '0));
endmodule

// File: rtl/lpd_coef_table.sv
// Dual-port complex gain table.
// One port gives a registered read every cycle. The other takes writes.
// A read and a write to the same entry at the same edge return the old
// value. Reset loads unity gain into every entry.
// Assumes: at most one write per edge.
module lpd_coef_table #(
    parameter int AW   = lpd_pkg::TBL_AW,
    parameter int CW   = lpd_pkg::COEF_W,
    parameter int FRAC = lpd_pkg::COEF_FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [CW-1:0] rd_i,
    output logic signed [CW-1:0] rd_q,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_i,
    input  logic signed [CW-1:0] wr_q
);
    localparam int DEPTH = 1 << AW;
    localparam logic signed [CW-1:0] UNITY = CW'(1 << FRAC);

    logic signed [CW-1:0] mem_i [DEPTH];
    logic signed [CW-1:0] mem_q [DEPTH];

    // Registered read of the old contents; write after it; unity on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_i[k] <= UNITY;
                mem_q[k] <= '0;
            end
            rd_i <= '0;
            rd_q <= '0;
        end else begin
            rd_i <= mem_i[rd_addr];
            rd_q <= mem_q[rd_addr];
            if (wr_en) begin
                mem_i[wr_addr] <= wr_i;
                mem_q[wr_addr] <= wr_q;
            end
        end
    end

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_i[$past(wr_addr)] == $past(wr_i) &&
                   mem_q[$past(wr_addr)] == $past(wr_q)));
endmodule

// File: rtl/lpd_cmul.sv
// Complex gain multiplier with rounding and saturation.
// Stage A registers four real products. Stage B forms the real part by
// subtraction and the imaginary part by addition. It then rounds half up
// at the gain's binary point and clamps to the sample width.
// Assumes: the sample and the gain arrive in the same cycle.
module lpd_cmul #(
    parameter int SW   = lpd_pkg::SAMPLE_W,
    parameter int CW   = lpd_pkg::COEF_W,
    parameter int FRAC = lpd_pkg::COEF_FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] xi,
    input  logic signed [SW-1:0] xq,
    input  logic signed [CW-1:0] gi,
    input  logic signed [CW-1:0] gq,
    output logic                 out_valid,
    output logic signed [SW-1:0] yi,
    output logic signed [SW-1:0] yq
);
    localparam int PW   = SW + CW;
    localparam int SUMW = PW + 1;
    localparam logic signed [SUMW-1:0] HALF = SUMW'(1 << (FRAC - 1));
    localparam logic signed [SUMW-1:0] MAXV = SUMW'((1 << (SW - 1)) - 1);
    localparam logic signed [SUMW-1:0] MINV = SUMW'(-(1 << (SW - 1)));
    localparam logic signed [CW-1:0]   UNITY = CW'(1 << FRAC);

    logic signed [PW-1:0]   p_ii, p_qq, p_qi, p_iq;
    logic                   p_valid;
    logic signed [SUMW-1:0] sum_re, sum_im, rnd_re, rnd_im;

    function automatic logic signed [SW-1:0] clamp(input logic signed [SUMW-1:0] v);
        if (v > MAXV)      return MAXV[SW-1:0];
        else if (v < MINV) return MINV[SW-1:0];
        else               return v[SW-1:0];
    endfunction

    // Stage A: the four real products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ii <= '0; p_qq <= '0; p_qi <= '0; p_iq <= '0;
            p_valid <= 1'b0;
        end else begin
            p_ii <= PW'(xi) * PW'(gi);
            p_qq <= PW'(xq) * PW'(gq);
            p_qi <= PW'(xq) * PW'(gi);
            p_iq <= PW'(xi) * PW'(gq);
            p_valid <= in_valid;
        end
    end

    assign sum_re = SUMW'(p_ii) - SUMW'(p_qq);
    assign sum_im = SUMW'(p_qi) + SUMW'(p_iq);
    assign rnd_re = (sum_re + HALF) >>> FRAC;
    assign rnd_im = (sum_im + HALF) >>> FRAC;

    // Stage B: round, saturate and register the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yi <= '0;
            yq <= '0;
            out_valid <= 1'b0;
        end else begin
            yi <= clamp(rnd_re);
            yq <= clamp(rnd_im);
            out_valid <= p_valid;
        end
    end

    // R4
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gi == UNITY && gq == '0) |-> ##2 (yi == $past(xi, 2) && yq == $past(xq, 2)));
endmodule

// File: rtl/lut_predistorter.sv
// Forward path of an envelope-indexed lookup-table predistorter.
// The squared envelope selects a complex gain from a live-writable table.
// A matched delay line carries each sample to its own gain, and the
// complex product is rounded and saturated back to sample width.
// Latency is 5 cycles, with one sample accepted per cycle.
// Assumes: at most one coefficient write per cycle.
module lut_predistorter #(
    parameter int SW   = lpd_pkg::SAMPLE_W,
    parameter int CW   = lpd_pkg::COEF_W,
    parameter int FRAC = lpd_pkg::COEF_FRAC,
    parameter int AW   = lpd_pkg::TBL_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_i,
    input  logic signed [SW-1:0] in_q,
    input  logic                 cw_en,
    input  logic [AW-1:0]        cw_addr,
    input  logic signed [CW-1:0] cw_i,
    input  logic signed [CW-1:0] cw_q,
    output logic                 out_valid,
    output logic signed [SW-1:0] out_i,
    output logic signed [SW-1:0] out_q
);
    localparam int ADDR_LAT = 2;
    localparam int RD_LAT   = 1;
    localparam int SDLY     = ADDR_LAT + RD_LAT;

    logic                 addr_valid, tbl_valid;
    logic [AW-1:0]        tbl_addr;
    logic signed [CW-1:0] g_i, g_q;
    logic signed [SW-1:0] dl_i [SDLY];
    logic signed [SW-1:0] dl_q [SDLY];

    lpd_addr_map #(.SW(SW), .AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .addr_valid(addr_valid), .addr(tbl_addr)
    );

    lpd_coef_table #(.AW(AW), .CW(CW), .FRAC(FRAC)) u_table (
        .clk(clk), .rst_n(rst_n), .rd_addr(tbl_addr),
        .rd_i(g_i), .rd_q(g_q),
        .wr_en(cw_en), .wr_addr(cw_addr), .wr_i(cw_i), .wr_q(cw_q)
    );

    // Qualifier for the registered table read
    always_ff @(posedge clk) begin
        if (!rst_n) tbl_valid <= 1'b0;
        else        tbl_valid <= addr_valid;
    end

    // Sample delay matching the address and table-read stages
    for (genvar s = 0; s < SDLY; s++) begin : g_dly
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dl_i[s] <= '0;
                dl_q[s] <= '0;
            end else if (s == 0) begin
                dl_i[s] <= in_i;
                dl_q[s] <= in_q;
            end else begin
                dl_i[s] <= dl_i[(s == 0) ? 0 : s - 1];
                dl_q[s] <= dl_q[(s == 0) ? 0 : s - 1];
            end
        end
    end

    lpd_cmul #(.SW(SW), .CW(CW), .FRAC(FRAC)) u_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(tbl_valid),
        .xi(dl_i[SDLY-1]), .xq(dl_q[SDLY-1]), .gi(g_i), .gq(g_q),
        .out_valid(out_valid), .yi(out_i), .yq(out_q)
    );

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 5));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_i == '0 && out_q == '0));
endmodule

// File: tb/lut_predistorter_tb.sv
module lut_predistorter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 4096;
    localparam int WD_CYCLES  = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic cw_en = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [6:0] cw_addr = '0;
    logic signed [11:0] cw_i = '0, cw_q = '0;
    logic out_valid;
    logic signed [15:0] out_i, out_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_predistorter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cw_en(cw_en), .cw_addr(cw_addr), .cw_i(cw_i), .cw_q(cw_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    int tbl_i [128];
    int tbl_q [128];
    int s_i [MAXC];
    int s_q [MAXC];
    int s_a [MAXC];
    int s_v [MAXC];
    int e_i [MAXC];
    int e_q [MAXC];
    string s_tag [MAXC];
    int t = 0;

    function automatic int map_addr(int i, int q);
        longint m = longint'(i) * i + longint'(q) * q;
        if (m >= 64'sd1073741824) return 127;
        return int'(m >>> 23);
    endfunction

    function automatic int rnd_sat(longint s);
        longint r = (s + 512) >>> 10;
        if (r > 32767) return 32767;
        if (r < -32768) return -32768;
        return int'(r);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0d)", tag, what, act, exp, t);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; cw_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_i in reset", int'(out_i), 0);
        check("R1", "out_q in reset", int'(out_q), 0);
        for (int a = 0; a < 128; a++) begin
            tbl_i[a] = 1024;
            tbl_q[a] = 0;
        end
        t = 0;
        rst_n = 1'b1;
    endtask

    // One cycle: drive, advance the reference model, compare the outputs
    task automatic step(bit v, int i, int q, bit we, int wa, int wi, int wq, string tag);
        int k, gi, gq;
        in_valid = v; in_i = 16'(i); in_q = 16'(q);
        cw_en = we; cw_addr = 7'(wa); cw_i = 12'(wi); cw_q = 12'(wq);
        s_i[t] = i; s_q[t] = q; s_v[t] = int'(v); s_tag[t] = tag;
        s_a[t] = map_addr(i, q);
        @(posedge clk);
        if (t >= 2) begin
            k = t - 2;
            gi = tbl_i[s_a[k]];
            gq = tbl_q[s_a[k]];
            e_i[k] = rnd_sat(longint'(s_i[k]) * gi - longint'(s_q[k]) * gq);
            e_q[k] = rnd_sat(longint'(s_q[k]) * gi + longint'(s_i[k]) * gq);
        end
        if (we) begin
            tbl_i[wa] = wi;
            tbl_q[wa] = wq;
        end
        @(negedge clk);
        if (t >= 4) begin
            k = t - 4;
            check("R2", "out_valid", int'(out_valid), s_v[k]);
            if (s_v[k] != 0) begin
                check(s_tag[k], "out_i", int'(out_i), e_i[k]);
                check(s_tag[k], "out_q", int'(out_q), e_q[k]);
            end
        end else begin
            check("R2", "out_valid early", int'(out_valid), 0);
        end
        if (t < MAXC - 1) t++;
    endtask

    task automatic idle(int n, string tag);
        for (int j = 0; j < n; j++) step(1'b0, 0, 0, 1'b0, 0, 0, 0, tag);
    endtask

    function automatic int rs16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: unity table after reset passes samples unchanged
        for (int n = 0; n < 24; n++) step(1'b1, rs16(), rs16(), 1'b0, 0, 0, 0, "R1");
        // R2: gaps in the valid stream
        for (int n = 0; n < 16; n++) step(n % 3 == 0, rs16(), rs16(), 1'b0, 0, 0, 0, "R2");
        idle(5, "R2");

        // R3: give every entry a distinct gain, then probe address boundaries
        for (int a = 0; a < 128; a++) step(1'b0, 0, 0, 1'b1, a, 1024 - 6 * a, 3 * a - 190, "R3");
        step(1'b1, 0, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 2896, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 2897, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 0, -2897, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 6700, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 23170, 23170, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 32767, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, -32768, 0, 1'b0, 0, 0, 0, "R3");
        step(1'b1, -32768, -32768, 1'b0, 0, 0, 0, "R3");
        step(1'b1, 16384, -16384, 1'b0, 0, 0, 0, "R3");
        idle(5, "R3");

        // R4: rounding of the complex product on entry 0
        step(1'b0, 0, 0, 1'b1, 0, 512, -300, "R4");
        idle(2, "R4");
        step(1'b1, 3, -1, 1'b0, 0, 0, 0, "R4");
        step(1'b1, -3, 1, 1'b0, 0, 0, 0, "R4");
        step(1'b1, 1, 1, 1'b0, 0, 0, 0, "R4");
        step(1'b1, -1, -1, 1'b0, 0, 0, 0, "R4");
        step(1'b1, 2000, -1500, 1'b0, 0, 0, 0, "R4");
        step(1'b1, -777, 1234, 1'b0, 0, 0, 0, "R4");
        idle(5, "R4");

        // R5: saturation at full scale on entry 127
        step(1'b0, 0, 0, 1'b1, 127, 2047, 2047, "R5");
        idle(2, "R5");
        step(1'b1, 32767, -32768, 1'b0, 0, 0, 0, "R5");
        step(1'b1, -32768, 32767, 1'b0, 0, 0, 0, "R5");
        step(1'b0, 0, 0, 1'b1, 127, -2048, 0, "R5");
        idle(2, "R5");
        step(1'b1, -32768, 0, 1'b0, 0, 0, 0, "R5");
        step(1'b1, 32767, 32767, 1'b0, 0, 0, 0, "R5");
        idle(5, "R5");

        // R6: rewrite entry 5 while samples that use it keep streaming
        for (int n = 0; n < 40; n++)
            step(1'b1, 6600 + 50 * (n % 4), n % 7 - 3, n % 3 == 0, 5,
                 int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, "R6");
        idle(5, "R6");

        // R7: a write at the same edge as the read returns the old gain
        step(1'b1, 6700, 0, 1'b0, 0, 0, 0, "R7");
        step(1'b0, 0, 0, 1'b0, 0, 0, 0, "R7");
        step(1'b0, 0, 0, 1'b1, 5, -700, 300, "R7");
        step(1'b1, 6700, 0, 1'b0, 0, 0, 0, "R7");
        step(1'b0, 0, 0, 1'b1, 5, 900, -50, "R7");
        step(1'b1, 6700, 100, 1'b1, 5, 100, 100, "R7");
        idle(5, "R7");

        // R8: back-to-back samples on different entries with random writes
        for (int n = 0; n < 300; n++)
            step($urandom_range(0, 3) != 0, rs16(), rs16(), $urandom_range(0, 2) == 0,
                 int'($urandom_range(0, 127)),
                 int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048, "R8");
        idle(5, "R8");

        // R1: reset restores unity gain in every entry
        do_reset();
        for (int n = 0; n < 20; n++) step(1'b1, rs16(), rs16(), 1'b0, 0, 0, 0, "R1");
        idle(5, "R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule